// File: doc/BRIEF.md
# Clock-Loss Fallback Selector

This block chooses the system clock among three sources: the crystal oscillator clock, the PLL clock, and a self-clock, which is the VCO held at its lowest frequency. In normal operation it follows the PLL select bit. When a clock-quality checker reports that the external clock has gone away, it falls back to the self-clock. The loss may come from a failure or from a crystal that is slow to start. Fallback happens only if both the clock-monitor enable and the self-clock enable are set. If the monitor is enabled but self-clock fallback is not, the block raises a clock-monitor reset request instead.

On entry to fallback the block pulses a clear for the PLL select bit, so that software sees the PLL deselected. Recovery needs the clock-good indication to hold for a programmable run of consecutive control cycles. It always lands on the oscillator clock, never on the PLL. A status output shows self-clock mode, and a sticky flag records every entry and every exit. All control decisions are registered on a free-running control clock.

Source changes go through one gate per clock source. Each gate has an enable chain clocked on the falling edge of its own source clock, so a source is switched off, then the next is switched on, each at a low phase. The oscillator gate can also be cleared at once on fallback, so a dead oscillator can never stall the switch.

Top module: `clk_fallback_sel`

## Requirements
- R1: While reset is held and in the first cycle after it, `sys_sel` is 0 (oscillator), and `scm_mode`, `pll_sel_clr`, `mon_rst_req` and `scm_change` are all 0.
- R2: In normal mode, on each control clock edge `sys_sel` takes the encoding of `pll_sel_in`: 0 selects the oscillator and 1 selects the PLL.
- R3: In normal mode, if `clk_good` is 0 at a control edge while `mon_en` and `scm_en` are both 1, then after that edge `scm_mode` is 1 and `sys_sel` is 2 (self-clock).
- R4: If either enable is 0, clock loss never enters self-clock mode. When `mon_en` is 0, loss has no visible effect: `sys_sel` keeps following `pll_sel_in`, and `mon_rst_req` stays 0.
- R5: `pll_sel_clr` is a one-cycle pulse that appears together with entry into self-clock mode, and only when `pll_sel_in` was 1 at the entry edge.
- R6: In self-clock mode, the block returns to normal on the RECOV_CNT-th consecutive edge with `clk_good` at 1. A 0 restarts the count. In the exit cycle `sys_sel` is 0 (oscillator), even if the PLL had been selected before the loss.
- R7: In normal mode, with `mon_en` at 1 and `scm_en` at 0, each edge that sees `clk_good` at 0 drives `mon_rst_req` to 1 for the following cycle. Otherwise it is 0.
- R8: `scm_change` is set on every entry to and every exit from self-clock mode, and is cleared by `chg_clr`. When a set and a clear fall in the same cycle, the set wins.
- R9: `sys_clk` never shows a high or low phase shorter than the shortest source half-period. Once a switch has settled, it runs at the period of the selected source.
- R10: With the oscillator stopped and held low, fallback still brings the self-clock out on `sys_clk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ctl_clk | input | 1 | Free-running control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| osc_clk | input | 1 | Crystal oscillator clock |
| pll_clk | input | 1 | PLL output clock |
| scm_clk | input | 1 | VCO at minimum frequency (self-clock) |
| clk_good | input | 1 | External clock present, from the quality checker |
| mon_en | input | 1 | Clock-monitor enable |
| scm_en | input | 1 | Self-clock fallback enable |
| pll_sel_in | input | 1 | Current PLL select bit |
| chg_clr | input | 1 | Clears the sticky mode-change flag |
| sys_clk | output | 1 | Glitch-free system clock |
| sys_sel | output | 2 | Selected source: 0 oscillator, 1 PLL, 2 self-clock |
| scm_mode | output | 1 | Self-clock mode status |
| pll_sel_clr | output | 1 | One-cycle request to clear the PLL select bit |
| mon_rst_req | output | 1 | Clock-monitor reset request |
| scm_change | output | 1 | Sticky flag: self-clock mode entered or left |

## Verification
The sticky change flag can be set by a mode transition and cleared by `chg_clr` in the same control cycle. The bench provokes this by holding `chg_clr` high across the edge that completes the recovery count. It expects the flag still set after that edge and cleared one edge later. A sweep covers all eight combinations of the two enables and the PLL select. For each combination, the expected mode, select code, clear pulse and reset request are computed from the bits, and `sys_clk` pulse widths and periods are measured across every switch.

// File: rtl/cfs_pkg.sv
`timescale 1ns/1ps
package cfs_pkg;
   localparam int NSRC = 3;

   typedef enum logic [1:0] {
      SRC_OSC  = 2'd0,
      SRC_PLL  = 2'd1,
      SRC_SELF = 2'd2
   } src_t;

   typedef enum logic {
      MODE_NORM = 1'b0,
      MODE_SELF = 1'b1
   } mode_t;
endpackage

// File: rtl/cfs_ctrl.sv
`timescale 1ns/1ps
module cfs_ctrl
   import cfs_pkg::*;
#(
   parameter int RECOV_CNT = 4
) (
   input  logic ctl_clk,
   input  logic rst_n,
   input  logic clk_good,
   input  logic mon_en,
   input  logic scm_en,
   input  logic pll_sel_in,
   input  logic chg_clr,
   output src_t sel_o,
   output logic scm_o,
   output logic pll_clr_o,
   output logic rst_req_o,
   output logic chg_o
);
   localparam int CW = (RECOV_CNT > 1) ? $clog2(RECOV_CNT) : 1;
   localparam logic [CW-1:0] LAST = CW'(RECOV_CNT - 1);

   generate
      if (RECOV_CNT < 1) begin : g_bad_recov
         $error("RECOV_CNT must be at least 1");
      end
   endgenerate

   mode_t         mode_q;
   logic [CW-1:0] good_cnt_q;
   logic          enter, leave;

   assign enter = (mode_q == MODE_NORM) && !clk_good && mon_en && scm_en;
   assign leave = (mode_q == MODE_SELF) && clk_good && (good_cnt_q == LAST);

   always_ff @(posedge ctl_clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q     <= MODE_NORM;
         sel_o      <= SRC_OSC;
         good_cnt_q <= '0;
         pll_clr_o  <= 1'b0;
         rst_req_o  <= 1'b0;
      end else begin
         pll_clr_o <= 1'b0;
         rst_req_o <= 1'b0;
         if (mode_q == MODE_NORM) begin
            if (enter) begin
               mode_q     <= MODE_SELF;
               sel_o      <= SRC_SELF;
               pll_clr_o  <= pll_sel_in;
               good_cnt_q <= '0;
            end else begin
               sel_o     <= pll_sel_in ? SRC_PLL : SRC_OSC;
               rst_req_o <= !clk_good && mon_en && !scm_en;
            end
         end else begin
            if (!clk_good) begin
               good_cnt_q <= '0;
            end else if (leave) begin
               mode_q     <= MODE_NORM;
               sel_o      <= SRC_OSC;
               good_cnt_q <= '0;
            end else begin
               good_cnt_q <= good_cnt_q + 1'b1;
            end
         end
      end
   end

   always_ff @(posedge ctl_clk or negedge rst_n) begin
      if (!rst_n)              chg_o <= 1'b0;
      else if (enter || leave) chg_o <= 1'b1;
      else if (chg_clr)        chg_o <= 1'b0;
   end

   assign scm_o = (mode_q == MODE_SELF);

   // R3
   enter_needs_en_chk: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      $rose(scm_o) |-> $past(mon_en && scm_en && !clk_good) && sel_o == SRC_SELF);

   // R5
   pll_clr_on_entry_chk: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      pll_clr_o |-> scm_o && $past(!scm_o) && $past(pll_sel_in));

   // R6
   exit_to_osc_chk: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      $fell(scm_o) |-> sel_o == SRC_OSC && $past(clk_good));

   // R7
   rst_req_cond_chk: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      rst_req_o |-> !scm_o && $past(mon_en && !scm_en && !clk_good));

   // R8
   chg_sticky_chk: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      (scm_o != $past(scm_o)) |-> chg_o);
endmodule

// File: rtl/cfs_gate.sv
`timescale 1ns/1ps
module cfs_gate #(
   parameter int STAGES   = 2,
   parameter bit KILLABLE = 1'b0
) (
   input  logic src_clk,
   input  logic rst_n,
   input  logic kill,
   input  logic req,
   input  logic others_busy,
   output logic en_o,
   output logic gclk_o
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              clr;

   assign clr = !rst_n || (KILLABLE && kill);

   always_ff @(negedge src_clk or posedge clr) begin
      if (clr) chain_q <= '0;
      else     chain_q <= {chain_q[STAGES-2:0], req && !others_busy};
   end

   assign en_o   = chain_q[STAGES-1];
   assign gclk_o = src_clk & en_o;
endmodule

// File: rtl/clk_fallback_sel.sv
`timescale 1ns/1ps
module clk_fallback_sel
   import cfs_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int RECOV_CNT   = 4
) (
   input  logic       ctl_clk,
   input  logic       rst_n,
   input  logic       osc_clk,
   input  logic       pll_clk,
   input  logic       scm_clk,
   input  logic       clk_good,
   input  logic       mon_en,
   input  logic       scm_en,
   input  logic       pll_sel_in,
   input  logic       chg_clr,
   output logic       sys_clk,
   output logic [1:0] sys_sel,
   output logic       scm_mode,
   output logic       pll_sel_clr,
   output logic       mon_rst_req,
   output logic       scm_change
);
   src_t             sel;
   logic [NSRC-1:0]  src_clk;
   logic [NSRC-1:0]  gate_en;
   logic [NSRC-1:0]  gate_clk;

   assign src_clk = {scm_clk, pll_clk, osc_clk};

   cfs_ctrl #(.RECOV_CNT(RECOV_CNT)) u_ctrl (
      .ctl_clk    (ctl_clk),
      .rst_n      (rst_n),
      .clk_good   (clk_good),
      .mon_en     (mon_en),
      .scm_en     (scm_en),
      .pll_sel_in (pll_sel_in),
      .chg_clr    (chg_clr),
      .sel_o      (sel),
      .scm_o      (scm_mode),
      .pll_clr_o  (pll_sel_clr),
      .rst_req_o  (mon_rst_req),
      .chg_o      (scm_change)
   );

   generate
      for (genvar i = 0; i < NSRC; i++) begin : g_src
         logic busy_oth;
         assign busy_oth = |(gate_en & ~(NSRC'(1) << i));
         cfs_gate #(
            .STAGES   (SYNC_STAGES),
            .KILLABLE (i == int'(SRC_OSC))
         ) u_gate (
            .src_clk     (src_clk[i]),
            .rst_n       (rst_n),
            .kill        (scm_mode),
            .req         (sel == src_t'(i)),
            .others_busy (busy_oth),
            .en_o        (gate_en[i]),
            .gclk_o      (gate_clk[i])
         );
      end
   endgenerate

   assign sys_clk = |gate_clk;
   assign sys_sel = sel;

   // R9
   gate_excl_chk: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      $onehot0(gate_en));

   // R10
   osc_off_in_self_chk: assert property (@(posedge ctl_clk) disable iff (!rst_n)
      (scm_mode && $past(scm_mode)) |-> !gate_en[SRC_OSC]);
endmodule

// File: tb/clk_fallback_sel_tb.sv
`timescale 1ns/1ps
module clk_fallback_sel_tb;
   localparam real CLK_PERIOD = 10.0;
   localparam real OSC_HALF   = 7.0;
   localparam real PLL_HALF   = 3.0;
   localparam real SCM_HALF   = 11.0;
   localparam real MIN_W      = 3.0;
   localparam int  REC        = 4;

   logic ctl_clk = 0, osc_clk = 0, pll_clk = 0, scm_clk = 0;
   logic rst_n = 0, clk_good = 1, mon_en = 0, scm_en = 0, pll_sel_in = 0, chg_clr = 0;
   logic sys_clk, scm_mode, pll_sel_clr, mon_rst_req, scm_change;
   logic [1:0] sys_sel;
   bit osc_run = 1, mon_on = 0, seen = 0, done = 0;
   realtime last_edge = 0;
   int glitches = 0, vecs = 0, bad = 0;

   clk_fallback_sel #(.SYNC_STAGES(2), .RECOV_CNT(REC)) u_dut (
      .ctl_clk(ctl_clk), .rst_n(rst_n), .osc_clk(osc_clk), .pll_clk(pll_clk),
      .scm_clk(scm_clk), .clk_good(clk_good), .mon_en(mon_en), .scm_en(scm_en),
      .pll_sel_in(pll_sel_in), .chg_clr(chg_clr), .sys_clk(sys_clk),
      .sys_sel(sys_sel), .scm_mode(scm_mode), .pll_sel_clr(pll_sel_clr),
      .mon_rst_req(mon_rst_req), .scm_change(scm_change)
   );

   always #(CLK_PERIOD/2) ctl_clk = ~ctl_clk;
   always #(PLL_HALF) pll_clk = ~pll_clk;
   always #(SCM_HALF) scm_clk = ~scm_clk;
   initial forever begin
      if (osc_run) begin #(OSC_HALF) osc_clk = 1; #(OSC_HALF) osc_clk = 0; end
      else #(OSC_HALF);
   end

   always @(sys_clk) begin
      if (!mon_on) seen = 0;
      else begin
         if (seen && ($realtime - last_edge) < MIN_W - 0.001) glitches++;
         seen = 1;
         last_edge = $realtime;
      end
   end

   task automatic tick(); @(posedge ctl_clk); #1; endtask

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      vecs++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0d exp=%0d at %0t", req, act, exp, $time);
      end
   endtask

   task automatic period_chk(string req, real exp);
      realtime t0;
      @(posedge sys_clk); t0 = $realtime;
      @(posedge sys_clk);
      vecs++;
      if (($realtime - t0) > exp + 0.01 || ($realtime - t0) < exp - 0.01) begin
         bad++;
         $display("FAIL %s period act=%0.3f exp=%0.3f", req, $realtime - t0, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      if (!done) begin
         bad++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
         $finish;
      end
   end

   initial begin
      for (int c = 0; c < 8; c++) begin
         logic m, s, p, ent;
         m = c[2]; s = c[1]; p = c[0]; ent = m & s;
         // reset and R1 checks
         @(negedge ctl_clk);
         mon_on = 0; rst_n = 0; osc_run = 1; clk_good = 1; chg_clr = 0;
         mon_en = 0; scm_en = 0; pll_sel_in = 0;
         repeat (3) tick();
         check("R1 sel", sys_sel, 0);
         check("R1 mode", scm_mode, 0);
         check("R1 clr", pll_sel_clr, 0);
         check("R1 rstreq", mon_rst_req, 0);
         check("R1 chg", scm_change, 0);
         @(negedge ctl_clk);
         rst_n = 1; mon_en = m; scm_en = s; pll_sel_in = p;
         tick();
         check("R2 sel follows pll bit", sys_sel, {1'b0, p});
         repeat (5) tick();
         mon_on = 1;
         repeat (25) tick();
         period_chk("R9 normal source", p ? 2*PLL_HALF : 2*OSC_HALF);
         if (ent) begin
            @(negedge ctl_clk); osc_run = 0;
            repeat (4) tick();
         end
         // clock loss
         @(negedge ctl_clk); clk_good = 0;
         tick();
         check("R3 R4 mode on loss", scm_mode, ent);
         check("R3 sel on loss", sys_sel, ent ? 2 : {1'b0, p});
         check("R5 pll clear pulse", pll_sel_clr, ent & p);
         check("R7 reset request", mon_rst_req, m & ~s);
         check("R8 change on entry", scm_change, ent);
         @(negedge ctl_clk);
         if (pll_sel_clr) pll_sel_in = 0;
         tick();
         check("R5 pulse one cycle", pll_sel_clr, 0);
         check("R4 mode held", scm_mode, ent);
         if (ent) begin
            repeat (30) tick();
            period_chk("R10 self clock with osc stopped", 2*SCM_HALF);
            @(negedge ctl_clk); osc_run = 1; clk_good = 1;
            repeat (2) tick();
            @(negedge ctl_clk); clk_good = 0;
            tick();
            @(negedge ctl_clk); clk_good = 1;
            repeat (REC - 1) tick();
            check("R6 count restarted", scm_mode, 1);
            @(negedge ctl_clk); chg_clr = 1;
            tick();
            check("R6 exit", scm_mode, 0);
            check("R6 exit to osc", sys_sel, 0);
            check("R8 set wins over clear", scm_change, 1);
            tick();
            check("R8 cleared", scm_change, 0);
            @(negedge ctl_clk); chg_clr = 0;
            repeat (30) tick();
            period_chk("R9 R6 back on osc", 2*OSC_HALF);
         end else begin
            check("R7 request while lost", mon_rst_req, m & ~s);
            @(negedge ctl_clk); clk_good = 1;
            tick();
            check("R7 request drops", mon_rst_req, 0);
            check("R4 sel unaffected", sys_sel, {1'b0, p});
            check("R4 no change flag", scm_change, 0);
         end
         check("R9 no short pulses", glitches, 0);
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
   end
endmodule